// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register file of a serial port. It sits between a simple 32-bit register read/write port and two byte streams. One stream delivers received bytes under valid/ready. The other emits bytes to transmit as a one-cycle pulse with no backpressure. Bit-level serialisation, baud generation, parity, framing and any FIFO live elsewhere. This block holds the registers, keeps the three status flags and drives one level-sensitive interrupt.

The block holds seven word registers: status, data, baud divisor, three control words and a guard/prescaler word. Reads and writes of the status and data registers have side effects on the flags. Software clears flags by reading. A status write can either load the register or mask it, depending on the magnitude of the value written. Control word 1 gates reception and enables the receive interrupt.

Top module: `serial_reg_front`

## Requirements
- R1: `rx_ready_o` is high exactly while the receive-not-empty flag (status bit 5) is clear; a byte offered while it is low is not taken.
- R2: Every accepted byte is stored in the data register. Receive-not-empty is set only if control word 1 has both bit 13 (port enable) and bit 2 (receiver enable) set; otherwise the flag is left clear.
- R3: When an accepted byte sets receive-not-empty and control word 1 bit 5 (receive interrupt enable) is set, `irq_o` is high from the following cycle.
- R4: A status read (offset 0x00) returns the value held before the access, and afterwards transmission-complete (status bit 6) is clear.
- R5: A data read (offset 0x04) returns the stored byte zero-extended and masked to 10 bits. It then sets transmit-empty (status bit 7), clears receive-not-empty and drives `irq_o` low.
- R6: A data write with a value below 0xF000 pulses `tx_valid_o` for one cycle, one cycle later, with `tx_data_o` equal to the low byte, and it sets transmission-complete and clears transmit-empty. A data write of 0xF000 or above changes nothing and emits nothing.
- R7: A status write of at most 0x3FF loads the register. A larger value is ANDed into it. If receive-not-empty is clear afterwards, `irq_o` goes low.
- R8: A write to control word 1 (offset 0x0C) with bit 5 set while receive-not-empty is set drives `irq_o` high from the next cycle.
- R9: After reset the status register reads 0x000000C0, every other register reads zero, `irq_o` is low and `rx_ready_o` is high.
- R10: The baud divisor (0x08), control words 1 to 3 (0x0C, 0x10, 0x14) and guard word (0x18) read back the full 32-bit value last written. Any other offset, including one that is not a multiple of 4, reads zero, and a write to it has no effect.
- R11: Read data and `rvalid_o` appear in the cycle after a read request; `rvalid_o` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | RX_W | Received byte |
| rx_ready_o | output | 1 | Receive side can take a byte |
| tx_valid_o | output | 1 | Transmit byte pulse |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a request is a single cycle, that at most one register access happens per cycle, and that `rx_data_i` is stable whenever `rx_valid_i` is high. The receive assertions also assume that a receive handshake can coincide with a data read only while the flag is clear. The stimulus drives each access on a falling edge and drops `req_i` on the next one. It leaves an idle cycle between accesses and never offers a byte in the same cycle as a bus access. So every flag change can be traced to exactly one cause.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned IDX_SR   = 0;
  localparam int unsigned IDX_DR   = 1;
  localparam int unsigned IDX_BRR  = 2;
  localparam int unsigned IDX_CR1  = 3;
  localparam int unsigned IDX_CR2  = 4;
  localparam int unsigned IDX_CR3  = 5;
  localparam int unsigned IDX_GTPR = 6;
  localparam int unsigned NUM_CFG  = NUM_REGS - IDX_BRR;

  localparam int unsigned SR_TXE  = 7;
  localparam int unsigned SR_TC   = 6;
  localparam int unsigned SR_RXNE = 5;

  localparam int unsigned CR1_EN   = 13;
  localparam int unsigned CR1_RXIE = 5;
  localparam int unsigned CR1_RXEN = 2;

  localparam logic [31:0] SR_RST      = 32'h0000_00C0;
  localparam logic [31:0] SR_LOAD_MAX = 32'h0000_03FF;
  localparam logic [31:0] TX_LIMIT    = 32'h0000_F000;
  localparam logic [31:0] DR_RD_MASK  = 32'h0000_03FF;
endpackage

// File: rtl/serial_addr_dec.sv
module serial_addr_dec #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 7
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:2] == IDX_W'(g));
  end
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int unsigned NUM_CFG = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CFG-1:0]      we_i,
  input  logic [31:0]             wdata_i,
  output logic [NUM_CFG-1:0][31:0] q_o
);
  for (genvar k = 0; k < NUM_CFG; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[k] <= '0;
      else if (we_i[k]) q_o[k] <= wdata_i;
    end

    // R10
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[k] |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/serial_stat_ctl.sv
module serial_stat_ctl
  import serial_reg_pkg::*;
#(
  parameter int unsigned RX_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sr_rd_i,
  input  logic            sr_wr_i,
  input  logic            dr_rd_i,
  input  logic            dr_wr_i,
  input  logic            cr1_wr_i,
  input  logic [31:0]     wdata_i,
  input  logic            cr1_en_i,
  input  logic            cr1_rxen_i,
  input  logic            cr1_rxie_i,
  input  logic            rx_valid_i,
  input  logic [RX_W-1:0] rx_data_i,
  output logic            rx_ready_o,
  output logic [31:0]     sr_o,
  output logic [RX_W-1:0] dr_o,
  output logic            tx_valid_o,
  output logic [7:0]      tx_data_o,
  output logic            irq_o
);
  logic [31:0]     sr_q, sr_n;
  logic [RX_W-1:0] dr_q, dr_n;
  logic            irq_q, irq_n;
  logic            tx_fire, rx_fire, rx_on;

  assign rx_ready_o = ~sr_q[SR_RXNE];
  assign rx_fire    = rx_valid_i & rx_ready_o;
  assign rx_on      = cr1_en_i & cr1_rxen_i;
  assign tx_fire    = dr_wr_i && (wdata_i < TX_LIMIT);

  // bus effects first, receive event last so a byte is never lost
  always_comb begin
    sr_n  = sr_q;
    dr_n  = dr_q;
    irq_n = irq_q;
    if (sr_rd_i) sr_n[SR_TC] = 1'b0;
    if (dr_rd_i) begin
      sr_n[SR_TXE]  = 1'b1;
      sr_n[SR_RXNE] = 1'b0;
      irq_n         = 1'b0;
    end
    if (sr_wr_i) begin
      sr_n = (wdata_i <= SR_LOAD_MAX) ? wdata_i : (sr_q & wdata_i);
      if (!sr_n[SR_RXNE]) irq_n = 1'b0;
    end
    if (tx_fire) begin
      sr_n[SR_TC]  = 1'b1;
      sr_n[SR_TXE] = 1'b0;
    end
    if (cr1_wr_i && wdata_i[CR1_RXIE] && sr_q[SR_RXNE]) irq_n = 1'b1;
    if (rx_fire) begin
      dr_n = rx_data_i;
      if (rx_on) begin
        sr_n[SR_RXNE] = 1'b1;
        if (cr1_rxie_i) irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= SR_RST;
      dr_q       <= '0;
      irq_q      <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      sr_q       <= sr_n;
      dr_q       <= dr_n;
      irq_q      <= irq_n;
      tx_valid_o <= tx_fire;
      if (tx_fire) tx_data_o <= wdata_i[7:0];
    end
  end

  assign sr_o  = sr_q;
  assign dr_o  = dr_q;
  assign irq_o = irq_q;

  // R2
  rx_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fire |=> dr_q == $past(rx_data_i));
  // R2
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fire && !rx_on && !sr_wr_i |=> !sr_q[SR_RXNE]);
  // R3
  rx_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fire && rx_on && cr1_rxie_i |=> irq_q && sr_q[SR_RXNE]);
  // R4
  sr_rd_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_rd_i |=> !sr_q[SR_TC]);
  // R5
  dr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_rd_i && !rx_valid_i |=> !irq_q && sr_q[SR_TXE] && !sr_q[SR_RXNE]);
  // R6
  tx_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_wr_i && (wdata_i < TX_LIMIT) |=>
      tx_valid_o && tx_data_o == $past(wdata_i[7:0]) && sr_q[SR_TC] && !sr_q[SR_TXE]);
  // R6
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dr_wr_i && (wdata_i < TX_LIMIT)) |=> !tx_valid_o);
  // R7
  sr_wr_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i && !rx_valid_i |=> !sr_q[SR_RXNE] |-> !irq_q);
  // R8
  cr1_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr1_wr_i && wdata_i[CR1_RXIE] && sr_q[SR_RXNE] |=> irq_q);
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned RX_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              rx_valid_i,
  input  logic [RX_W-1:0]   rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  localparam int unsigned CR1_K = IDX_CR1 - IDX_BRR;

  logic [NUM_REGS-1:0]       sel;
  logic                      rd, wr;
  logic [NUM_CFG-1:0]        cfg_we;
  logic [NUM_CFG-1:0][31:0]  cfg_q;
  logic [31:0]               sr;
  logic [RX_W-1:0]           dr;
  logic [NUM_REGS-1:0][31:0] words;
  logic [31:0]               rd_word;

  assign rd = req_i & ~we_i;
  assign wr = req_i &  we_i;

  serial_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg_we
    assign cfg_we[k]          = wr & sel[IDX_BRR + k];
    assign words[IDX_BRR + k] = cfg_q[k];
  end

  serial_cfg_bank #(.NUM_CFG(NUM_CFG)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we),
    .wdata_i (wdata_i),
    .q_o     (cfg_q)
  );

  serial_stat_ctl #(.RX_W(RX_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sr_rd_i    (rd & sel[IDX_SR]),
    .sr_wr_i    (wr & sel[IDX_SR]),
    .dr_rd_i    (rd & sel[IDX_DR]),
    .dr_wr_i    (wr & sel[IDX_DR]),
    .cr1_wr_i   (wr & sel[IDX_CR1]),
    .wdata_i    (wdata_i),
    .cr1_en_i   (cfg_q[CR1_K][CR1_EN]),
    .cr1_rxen_i (cfg_q[CR1_K][CR1_RXEN]),
    .cr1_rxie_i (cfg_q[CR1_K][CR1_RXIE]),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .sr_o       (sr),
    .dr_o       (dr),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .irq_o      (irq_o)
  );

  assign words[IDX_SR] = sr;
  assign words[IDX_DR] = 32'(dr) & DR_RD_MASK;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) rd_word = rd_word | words[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_word;
    end
  end

  // R11
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  // R11
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (sel == '0) |=> rdata_o == 32'h0);
  // R4
  sr_rd_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel[IDX_SR] |=> rdata_o == $past(sr));
endmodule

// File: tb/sim_serial_reg_front.sv
module sim_serial_reg_front;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rd_val;
  logic        rd_vld, tx_seen, rx_took;
  logic [7:0]  tx_byte;

  always #5 clk_i = ~clk_i;

  serial_reg_front u0 (.*);

  // {is_read, addr, data/expected}
  localparam logic [40:0] VECS [0:11] = '{
    {1'b0, 8'h08, 32'h1234_5678},
    {1'b1, 8'h08, 32'h1234_5678},
    {1'b0, 8'h10, 32'hDEAD_BEEF},
    {1'b0, 8'h14, 32'h0000_FFFF},
    {1'b0, 8'h18, 32'hA5A5_0001},
    {1'b1, 8'h10, 32'hDEAD_BEEF},
    {1'b1, 8'h14, 32'h0000_FFFF},
    {1'b1, 8'h18, 32'hA5A5_0001},
    {1'b0, 8'h1C, 32'hFFFF_FFFF},
    {1'b1, 8'h1C, 32'h0000_0000},
    {1'b1, 8'h09, 32'h0000_0000},
    {1'b1, 8'h08, 32'h1234_5678}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    tx_seen = tx_valid_o; tx_byte = tx_data_o;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    rd_val = rdata_o; rd_vld = rvalid_o;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    rx_took = rx_ready_o;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state
    chk("R9 irq", {31'b0, irq_o}, 32'h0);
    chk("R9 ready", {31'b0, rx_ready_o}, 32'h1);
    bus_rd(8'h00); chk("R9 sr", rd_val, 32'hC0);
    chk("R11 rvalid", {31'b0, rd_vld}, 32'h1);
    @(negedge clk_i); chk("R11 rvalid pulse", {31'b0, rvalid_o}, 32'h0);
    bus_rd(8'h00); chk("R4 tc cleared", rd_val, 32'h80);
    bus_rd(8'h04); chk("R9 dr", rd_val, 32'h0);
    bus_rd(8'h0C); chk("R9 cr1", rd_val, 32'h0);
    bus_rd(8'h08); chk("R9 brr", rd_val, 32'h0);

    // R10 / R11 vector walk
    for (int i = 0; i < 12; i++) begin
      if (VECS[i][40]) begin
        bus_rd(VECS[i][39:32]);
        chk("R10 readback", rd_val, VECS[i][31:0]);
        chk("R11 valid", {31'b0, rd_vld}, 32'h1);
      end else begin
        bus_wr(VECS[i][39:32], VECS[i][31:0]);
      end
    end

    // R2 disabled receiver: byte stored, flag stays clear
    send_rx(8'h5A); chk("R1 accepted", {31'b0, rx_took}, 32'h1);
    bus_rd(8'h00); chk("R2 gated flag", rd_val, 32'h80);
    bus_rd(8'h04); chk("R2 stored", rd_val, 32'h5A);

    // R2/R3 enabled, no interrupt enable
    bus_wr(8'h0C, 32'h2004);
    send_rx(8'hA5);
    chk("R3 no ie", {31'b0, irq_o}, 32'h0);
    chk("R1 busy", {31'b0, rx_ready_o}, 32'h0);
    bus_rd(8'h00); chk("R2 flag set", rd_val, 32'hA0);
    send_rx(8'h11); chk("R1 refused", {31'b0, rx_took}, 32'h0);
    bus_wr(8'h0C, 32'h2024); chk("R8 irq on cr1", {31'b0, irq_o}, 32'h1);
    bus_rd(8'h04); chk("R5 data", rd_val, 32'hA5);
    chk("R5 irq low", {31'b0, irq_o}, 32'h0);
    chk("R1 ready again", {31'b0, rx_ready_o}, 32'h1);
    bus_rd(8'h00); chk("R5 flags", rd_val, 32'h80);

    // R3 interrupt on receive, R7 cleared by load
    send_rx(8'h3C); chk("R3 irq", {31'b0, irq_o}, 32'h1);
    bus_rd(8'h00); chk("R3 flag", rd_val, 32'hA0);
    bus_wr(8'h00, 32'h80); chk("R7 irq low", {31'b0, irq_o}, 32'h0);
    bus_rd(8'h00); chk("R7 load", rd_val, 32'h80);

    // R7 load then masking
    bus_wr(8'h00, 32'h3E0); chk("R7 load no irq", {31'b0, irq_o}, 32'h0);
    bus_rd(8'h00); chk("R7 load val", rd_val, 32'h3E0);
    bus_wr(8'h00, 32'hFFFF_FFDF);
    bus_rd(8'h00); chk("R7 and 1", rd_val, 32'h380);
    bus_wr(8'h00, 32'hFFFF_FF7F);
    bus_rd(8'h00); chk("R7 and 2", rd_val, 32'h300);

    // R6 transmit
    bus_wr(8'h00, 32'h80);
    bus_wr(8'h04, 32'h0141);
    chk("R6 tx pulse", {31'b0, tx_seen}, 32'h1);
    chk("R6 tx byte", {24'b0, tx_byte}, 32'h41);
    @(negedge clk_i); chk("R6 one cycle", {31'b0, tx_valid_o}, 32'h0);
    bus_rd(8'h00); chk("R6 flags", rd_val, 32'h40);
    bus_rd(8'h00); chk("R4 tc clear", rd_val, 32'h00);
    bus_wr(8'h04, 32'hF000); chk("R6 ignored", {31'b0, tx_seen}, 32'h0);
    bus_rd(8'h00); chk("R6 no flag", rd_val, 32'h00);
    bus_wr(8'h04, 32'hEFFF);
    chk("R6 edge byte", {23'b0, tx_seen, tx_byte}, 32'h1FF);
    bus_rd(8'h04); chk("R5 dr kept", rd_val, 32'h3C);
    bus_rd(8'h00); chk("R5 txe set", rd_val, 32'hC0);

    // R9 reset in the middle of activity
    send_rx(8'h77); chk("R3 irq pre reset", {31'b0, irq_o}, 32'h1);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);
    bus_rd(8'h00); chk("R9 sr after reset", rd_val, 32'hC0);
    bus_rd(8'h0C); chk("R9 cr1 after reset", rd_val, 32'h0);
    bus_rd(8'h04); chk("R9 dr after reset", rd_val, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule